// File: doc/BRIEF.md
# Bank-Granular DRAM Refresh Scheduler

This block decides when an eight-bank low-power DRAM must be refreshed, and which part of the device each refresh takes offline. It keeps time with a clock-cycle tick. In whole-device mode it owes one refresh per long interval. In single-bank mode it owes one refresh every eighth of that interval and walks through the banks in turn, so every bank still gets one refresh per long interval.

Owed refreshes are counted. The scheduler raises a request to the command arbiter only when the target bank, or every bank in whole-device mode, reports idle and is not already held. While that condition is false, the owed count keeps growing up to a ceiling. On a grant, the scheduler blocks traffic to the refreshed bank for the single-bank recovery time. In whole-device mode it blocks every bank for the longer whole-device recovery time instead. Both recovery times are parameters given in clock cycles.

Top module: `refsched_top`

## Requirements
- R1: After reset, no refresh is requested, no bank is blocked, the owed count is 0 and the target bank index is 0.
- R2: With `mode_per_bank` low, one refresh becomes owed on the tick that completes each run of INTERVAL_TICKS ticks. Cycles with `tick` low do not advance the interval.
- R3: With `mode_per_bank` high, one refresh becomes owed every INTERVAL_TICKS/8 ticks.
- R4: `ref_req` is high exactly when the owed count is nonzero and the target is ready. In single-bank mode the target is ready when bank `ref_bank` is idle and not blocked. In whole-device mode it is ready when all eight banks are idle and none is blocked. `ref_all` is 1 in whole-device mode and 0 in single-bank mode.
- R5: The owed count `owed` rises by one for each refresh that falls due and falls by one for each accepted grant. When both happen in the same cycle it is unchanged. It saturates at OWED_MAX.
- R6: A grant accepted in single-bank mode sets `bank_blocked[ref_bank]` from the next cycle for exactly TRFC_BANK cycles and leaves every other bank's blocked bit unchanged. Bit i of `bank_blocked` belongs to bank i.
- R7: A grant accepted in whole-device mode sets all eight `bank_blocked` bits from the next cycle for exactly TRFC_ALL cycles.
- R8: `ref_bank` steps 0,1,...,7 and then wraps to 0. It advances by one only on a grant accepted in single-bank mode; grants in whole-device mode leave it unchanged.
- R9: `ref_gnt` while `ref_req` is low has no effect on `owed`, `bank_blocked` or `ref_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advances the refresh interval by one unit |
| mode_per_bank | input | 1 | 1 selects single-bank refresh, 0 selects whole-device refresh |
| bank_idle | input | 8 | Bit i high when bank i is precharged and idle |
| ref_gnt | input | 1 | Arbiter grant; accepted in a cycle where ref_req is high |
| ref_req | output | 1 | Refresh slot request to the arbiter |
| ref_all | output | 1 | Requested refresh covers the whole device |
| ref_bank | output | 3 | Bank targeted by a single-bank refresh |
| bank_blocked | output | 8 | Bit i high while bank i is recovering from refresh |
| owed | output | $clog2(OWED_MAX+1) | Owed (postponed) refresh count |

## Verification
The scheduler is driven first with steady ticks, all banks idle and immediate grants in each mode. This separates the two interval lengths and the two recovery times. Sparse ticks and intermittent grants then show that the interval counts ticks rather than cycles, and that a due refresh and a grant in the same cycle cancel. A long stretch with one bank held busy in single-bank mode stalls the rotation at that bank and drives the owed count into saturation. Grants with every bank busy, and mode switches in the middle of a run, show that stray grants are ignored and that the pointer moves only on single-bank grants.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    localparam int BANKS      = 8;
    localparam int BANK_IDX_W = $clog2(BANKS);

    typedef logic [BANK_IDX_W-1:0] bank_idx_t;
    typedef logic [BANKS-1:0]      bank_mask_t;

    typedef enum logic {
        SCOPE_ALL  = 1'b0,
        SCOPE_BANK = 1'b1
    } ref_scope_e;

    typedef struct packed {
        logic       fire;
        ref_scope_e scope;
        bank_idx_t  bank;
    } ref_issue_t;

    function automatic bank_idx_t bank_after(bank_idx_t b);
        return bank_idx_t'((int'(b) + 1) % BANKS);
    endfunction

    function automatic bank_mask_t target_mask(ref_scope_e s, bank_idx_t b);
        bank_mask_t m;
        if (s == SCOPE_ALL) begin
            m = '1;
        end else begin
            m = '0;
            m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval
    import refsched_pkg::*;
#(
    parameter int INTERVAL_TICKS = 3120
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  ref_scope_e scope,
    output logic       due
);
    localparam int CW     = $clog2(INTERVAL_TICKS);
    localparam int LIM_AB = INTERVAL_TICKS - 1;
    localparam int LIM_PB = INTERVAL_TICKS / BANKS - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim = (scope == SCOPE_ALL) ? CW'(LIM_AB) : CW'(LIM_PB);
        due = tick && (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= due ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIM_AB));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
    parameter int OWED_MAX = 8,
    parameter int PW       = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          due,
    input  logic          fire,
    output logic [PW-1:0] owed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            unique case ({due, fire})
                2'b10:   if (owed != PW'(OWED_MAX)) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        owed <= PW'(OWED_MAX));

    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (owed == PW'(OWED_MAX) && due && !fire) |=> owed == PW'(OWED_MAX));

    assert_fire_needs_debt_R5: assert property (@(posedge clk) disable iff (rst)
        fire |-> owed != '0);

endmodule

// File: rtl/refsched_bank_timer.sv
module refsched_bank_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> cnt == $past(cnt) - 1'b1);

    assert_load_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> busy);

endmodule

// File: rtl/refsched_select.sv
module refsched_select
    import refsched_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ref_scope_e scope,
    input  logic       owed_nz,
    input  bank_mask_t bank_idle,
    input  bank_mask_t bank_busy,
    input  logic       ref_gnt,
    output logic       ref_req,
    output ref_issue_t issue
);
    bank_idx_t ptr;
    logic      ready;

    always_comb begin
        if (scope == SCOPE_BANK) begin
            ready = bank_idle[ptr] && !bank_busy[ptr];
        end else begin
            ready = (&bank_idle) && !(|bank_busy);
        end
        ref_req     = owed_nz && ready;
        issue.fire  = ref_req && ref_gnt;
        issue.scope = scope;
        issue.bank  = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (issue.fire && scope == SCOPE_BANK) begin
            ptr <= bank_after(ptr);
        end
    end

    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (issue.fire && scope == SCOPE_BANK) |=> ptr == bank_idx_t'($past(ptr) + 1'b1));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(issue.fire && scope == SCOPE_BANK) |=> $stable(ptr));

    assert_req_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (ref_req && scope == SCOPE_BANK) |-> !bank_busy[ptr]);

endmodule

// File: rtl/refsched_top.sv
module refsched_top
    import refsched_pkg::*;
#(
    parameter int INTERVAL_TICKS = 3120,
    parameter int TRFC_ALL       = 168,
    parameter int TRFC_BANK      = 72,
    parameter int OWED_MAX       = 8,
    parameter int PW             = $clog2(OWED_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  mode_per_bank,
    input  logic [BANKS-1:0]      bank_idle,
    input  logic                  ref_gnt,
    output logic                  ref_req,
    output logic                  ref_all,
    output logic [BANK_IDX_W-1:0] ref_bank,
    output logic [BANKS-1:0]      bank_blocked,
    output logic [PW-1:0]         owed
);
    localparam int TRFC_MAX = (TRFC_ALL > TRFC_BANK) ? TRFC_ALL : TRFC_BANK;
    localparam int TW       = $clog2(TRFC_MAX + 1);

    ref_scope_e    scope;
    logic          due;
    ref_issue_t    issue;
    bank_mask_t    load_mask;
    logic [TW-1:0] load_val;

    assign scope = mode_per_bank ? SCOPE_BANK : SCOPE_ALL;

    refsched_interval #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
        .clk(clk), .rst(rst), .tick(tick), .scope(scope), .due(due)
    );

    refsched_debt #(.OWED_MAX(OWED_MAX), .PW(PW)) u_debt (
        .clk(clk), .rst(rst), .due(due), .fire(issue.fire), .owed(owed)
    );

    refsched_select u_select (
        .clk(clk), .rst(rst), .scope(scope), .owed_nz(owed != '0),
        .bank_idle(bank_idle), .bank_busy(bank_blocked), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .issue(issue)
    );

    always_comb begin
        load_mask = issue.fire ? target_mask(issue.scope, issue.bank) : '0;
        load_val  = (issue.scope == SCOPE_ALL) ? TW'(TRFC_ALL) : TW'(TRFC_BANK);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        refsched_bank_timer #(.TW(TW)) u_timer (
            .clk(clk), .rst(rst), .load(load_mask[b]), .load_val(load_val),
            .busy(bank_blocked[b])
        );
    end

    assign ref_all  = (scope == SCOPE_ALL);
    assign ref_bank = issue.bank;

    assert_bank_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (issue.fire && mode_per_bank) |=> bank_blocked[$past(ref_bank)]);

    assert_all_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (issue.fire && !mode_per_bank) |=> &bank_blocked);

    assert_req_needs_debt_R4: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> owed != '0);

    assert_stray_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (ref_gnt && !ref_req) |=> $stable(ref_bank));

endmodule

// File: tb/refsched_top_tb.sv
`timescale 1ns/1ps
module refsched_top_tb;
    localparam int INT_T  = 128;
    localparam int T_ALL  = 21;
    localparam int T_BANK = 9;
    localparam int OMAX   = 8;
    localparam int PW     = $clog2(OMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          mode_per_bank = 1'b0;
    logic [7:0]    bank_idle = 8'hFF;
    logic          ref_gnt = 1'b0;
    logic          ref_req, ref_all;
    logic [2:0]    ref_bank;
    logic [7:0]    bank_blocked;
    logic [PW-1:0] owed;

    always #2 clk = ~clk;

    refsched_top #(.INTERVAL_TICKS(INT_T), .TRFC_ALL(T_ALL), .TRFC_BANK(T_BANK),
                   .OWED_MAX(OMAX)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .mode_per_bank(mode_per_bank),
        .bank_idle(bank_idle), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ref_all(ref_all), .ref_bank(ref_bank), .bank_blocked(bank_blocked),
        .owed(owed)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_tcnt, m_owed, m_ptr;
    int m_blk[8];
    int cyc = 0;
    bit stray_phase = 0;

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    function automatic bit m_ready();
        if (mode_per_bank) return bank_idle[m_ptr] && m_blk[m_ptr] == 0;
        for (int b = 0; b < 8; b++) if (!bank_idle[b] || m_blk[b] != 0) return 0;
        return 1;
    endfunction

    function automatic int m_mask();
        int v = 0;
        for (int b = 0; b < 8; b++) if (m_blk[b] != 0) v |= (1 << b);
        return v;
    endfunction

    task automatic compare();
        bit exp_req = (m_owed > 0) && m_ready();
        check(stray_phase ? "R4 R9 req" : "R4 req", ref_req, exp_req);
        check("R4 ref_all", ref_all, !mode_per_bank);
        check(stray_phase ? "R8 R9 bank" : "R8 bank", ref_bank, m_ptr);
        check(mode_per_bank ? "R6 blocked" : "R7 blocked", bank_blocked, m_mask());
        check(mode_per_bank ? "R3 R5 owed" : "R2 R5 owed", owed, m_owed);
    endtask

    task automatic advance_model();
        int lim = mode_per_bank ? INT_T / 8 : INT_T;
        bit due = tick && (m_tcnt >= lim - 1);
        bit acc = (m_owed > 0) && m_ready() && ref_gnt;
        if (tick) m_tcnt = due ? 0 : m_tcnt + 1;
        if (due && !acc && m_owed < OMAX) m_owed++;
        else if (acc && !due) m_owed--;
        for (int b = 0; b < 8; b++) begin
            if (acc && (!mode_per_bank || b == m_ptr)) m_blk[b] = mode_per_bank ? T_BANK : T_ALL;
            else if (m_blk[b] > 0) m_blk[b]--;
        end
        if (acc && mode_per_bank) m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic step(bit t, bit pb, logic [7:0] idle, bit g);
        @(negedge clk);
        tick = t; mode_per_bank = pb; bank_idle = idle; ref_gnt = g;
        #1;
        compare();
        @(posedge clk);
        advance_model();
        cyc++;
    endtask

    initial begin
        m_tcnt = 0; m_owed = 0; m_ptr = 0;
        for (int b = 0; b < 8; b++) m_blk[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 req", ref_req, 0);
        check("R1 blocked", bank_blocked, 0);
        check("R1 owed", owed, 0);
        check("R1 bank", ref_bank, 0);

        // whole-device, steady ticks, immediate grants
        for (int i = 0; i < 600; i++) step(1, 0, 8'hFF, 1);
        // whole-device, sparse ticks, intermittent grants (R2)
        for (int i = 0; i < 900; i++) step(i % 3 == 0, 0, 8'hFF, i % 7 == 0);
        // single-bank, steady ticks, immediate grants (R3, R6, R8)
        for (int i = 0; i < 600; i++) step(1, 1, 8'hFF, 1);
        // single-bank with rotating busy banks
        for (int i = 0; i < 600; i++) step(1, 1, ~(8'h01 << ((i / 11) % 8)), i % 2 == 0);
        // single-bank, bank 3 held busy long enough to saturate owed (R5)
        for (int i = 0; i < 400; i++) step(1, 1, 8'hF7, 1);
        for (int i = 0; i < 300; i++) step(1, 1, 8'hFF, 1);
        // stray grants with every bank busy (R9)
        stray_phase = 1;
        for (int i = 0; i < 200; i++) step(1, i % 2 == 0 ? 1'b1 : 1'b0, 8'h00, 1);
        stray_phase = 0;
        // mode switches mid-run (R8 pointer only moves on single-bank grants)
        for (int i = 0; i < 1200; i++) step(1, (i / 37) % 2 == 1, 8'hFF, i % 3 != 0);
        for (int i = 0; i < 300; i++) step(1, 0, 8'hFF, 1);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule